// File: doc/BRIEF.md
# Lease-Expiring Write-Through L1 Data Cache

This block is a small direct-mapped private data cache for one core. Each line holds a tag, one data word and an absolute expiry time. Every cache on the chip sees the same time value, which advances in lockstep. A line serves loads only while its expiry lies ahead of that shared time. Once the time reaches the expiry, the line is stale. The cache needs no invalidation message, no sharer list and no transient coherence state to make this happen.

Loads that find a live line get their data back locally one cycle later. A load to a missing or stale line sends a read to the next level and waits for the response. The response carries the word and a new expiry, and both are written into the line. Stores always go through to the next level. A store that hits a live line also updates the local word, but its expiry does not move. Only one next-level transaction is in flight at a time, and the core-side ready is low while it is pending.

Top module: `lease_l1_cache`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both `rsp_valid_o` and `nl_req_valid_o` are 0. Every line is empty, so the first load to any address misses.
- R2: A load to a live line with a matching tag is a hit. `rsp_valid_o` rises the cycle after acceptance with the stored word, and no next-level request is issued.
- R3: A line is live when `d = (expiry - now_i) mod 2^TW` satisfies `1 <= d <= 2^(TW-1)-1`. At `expiry == now_i` the line is stale, and the comparison stays correct across counter wraparound.
- R4: A load miss raises `nl_req_valid_o` with `nl_req_write_o`=0 and `nl_req_addr_o` set to the load address. The request stays asserted and stable until `nl_req_ready_i` is high.
- R5: In the cycle `nl_rsp_valid_i` is high during a pending miss, the line takes its tag, word and expiry from the response. `rsp_valid_o` returns that word one cycle later.
- R6: A store issues a next-level request with `nl_req_write_o`=1 and the store's address and data. A store never produces `rsp_valid_o`.
- R7: A store that hits a live line updates the cached word but leaves the line's expiry unchanged.
- R8: A store to a missing or stale line does not allocate or refresh the line.
- R9: `req_ready_o` is 0 from the cycle after a miss or store is accepted until its next-level transaction completes. `nl_req_valid_o` is never 1 while `req_ready_o` is 1.
- R10: A live line keeps returning its cached word even when the next-level copy has changed, and it stops doing so exactly at expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_i | input | TW | Chip-wide synchronized time |
| req_valid_i | input | 1 | Core request valid |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | AW | Word address; low IW bits select the line |
| req_wdata_i | input | DW | Store data |
| req_ready_o | output | 1 | Cache can accept a request |
| rsp_valid_o | output | 1 | Load data valid |
| rsp_rdata_o | output | DW | Load data |
| nl_req_valid_o | output | 1 | Next-level request valid |
| nl_req_write_o | output | 1 | Next-level request is a write-through |
| nl_req_addr_o | output | AW | Next-level request address |
| nl_req_wdata_o | output | DW | Write-through data |
| nl_req_ready_i | input | 1 | Next level accepts the request |
| nl_rsp_valid_i | input | 1 | Fill response valid |
| nl_rsp_data_i | input | DW | Fill data |
| nl_rsp_expiry_i | input | TW | Absolute expiry of the filled line |

## Verification
The assertions check the handshake rules on every cycle:
- a request is held stable until it is accepted;
- no next-level request appears while the core side is ready;
- every load response follows a hit or a fill;
- stores never answer and hits never reach the next level.

The bench scenarios cover what depends on stored state:
- the exact stale point at expiry and its behaviour across wraparound;
- stores leaving the expiry untouched;
- store misses not allocating;
- a live line hiding a newer next-level value until its lease ends.

// File: rtl/lease_pkg.sv
package lease_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } lease_state_e;

  // A line is live while (expiry - now) mod 2^tw lies in [1, 2^(tw-1)-1]; tw <= 31.
  function automatic logic lease_live(logic [31:0] expiry, logic [31:0] now, int unsigned tw);
    logic [31:0] mask;
    logic [31:0] diff;
    mask = (32'h1 << tw) - 32'h1;
    diff = (expiry - now) & mask;
    return (diff != 32'h0) && (diff[tw-1] == 1'b0);
  endfunction

endpackage

// File: rtl/lease_lines.sv
module lease_lines #(
  parameter int NL  = 4,
  parameter int IW  = 2,
  parameter int TGW = 6,
  parameter int DW  = 16,
  parameter int TW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IW-1:0]  rd_idx,
  output logic           rd_valid,
  output logic [TGW-1:0] rd_tag,
  output logic [DW-1:0]  rd_data,
  output logic [TW-1:0]  rd_exp,
  input  logic           fill_we,
  input  logic [IW-1:0]  fill_idx,
  input  logic [TGW-1:0] fill_tag,
  input  logic [DW-1:0]  fill_data,
  input  logic [TW-1:0]  fill_exp,
  input  logic           upd_we,
  input  logic [IW-1:0]  upd_idx,
  input  logic [DW-1:0]  upd_data
);
  logic           vld_q  [NL];
  logic [TGW-1:0] tag_q  [NL];
  logic [DW-1:0]  data_q [NL];
  logic [TW-1:0]  exp_q  [NL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin
        vld_q[i]  <= 1'b0;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
        exp_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NL; i++) begin
        if (fill_we && fill_idx == IW'(i)) begin
          vld_q[i]  <= 1'b1;
          tag_q[i]  <= fill_tag;
          data_q[i] <= fill_data;
          exp_q[i]  <= fill_exp;
        end else if (upd_we && upd_idx == IW'(i)) begin
          data_q[i] <= upd_data;
        end
      end
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
  assign rd_exp   = exp_q[rd_idx];
endmodule

// File: rtl/lease_probe.sv
module lease_probe #(
  parameter int TGW = 6,
  parameter int TW  = 16
) (
  input  logic           line_valid,
  input  logic [TGW-1:0] line_tag,
  input  logic [TW-1:0]  line_exp,
  input  logic [TGW-1:0] req_tag,
  input  logic [TW-1:0]  now,
  output logic           hit
);
  import lease_pkg::*;
  logic tag_eq;
  logic alive;
  assign tag_eq = line_valid && (line_tag == req_tag);
  assign alive  = lease_live(32'(line_exp), 32'(now), TW);
  assign hit    = tag_eq && alive;
endmodule

// File: rtl/lease_ctrl.sv
module lease_ctrl #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          line_hit,
  input  logic [DW-1:0] line_data,
  input  logic          nl_req_ready_i,
  input  logic          nl_rsp_valid_i,
  input  logic [DW-1:0] nl_rsp_data_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          nl_req_valid_o,
  output logic          nl_req_write_o,
  output logic [AW-1:0] nl_req_addr_o,
  output logic [DW-1:0] nl_req_wdata_o,
  output logic          acc_load_hit,
  output logic          acc_store,
  output logic          store_upd,
  output logic          fill_take,
  output logic [AW-1:0] pend_addr
);
  import lease_pkg::*;
  lease_state_e  state_q, state_d;
  logic          accept;
  logic          acc_load_miss;
  logic          pend_write_q;
  logic [AW-1:0] pend_addr_q;
  logic [DW-1:0] pend_wdata_q;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;

  assign accept        = req_valid_i && (state_q == ST_IDLE);
  assign acc_load_hit  = accept && !req_write_i && line_hit;
  assign acc_load_miss = accept && !req_write_i && !line_hit;
  assign acc_store     = accept && req_write_i;
  assign store_upd     = acc_store && line_hit;
  assign fill_take     = (state_q == ST_WAIT) && nl_rsp_valid_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (acc_load_miss || acc_store) state_d = ST_SEND;
      ST_SEND: if (nl_req_ready_i) state_d = pend_write_q ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (nl_rsp_valid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      pend_write_q <= 1'b0;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_data_q   <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= acc_load_hit || fill_take;
      if (fill_take)         rsp_data_q <= nl_rsp_data_i;
      else if (acc_load_hit) rsp_data_q <= line_data;
      if (acc_load_miss || acc_store) begin
        pend_write_q <= req_write_i;
        pend_addr_q  <= req_addr_i;
        pend_wdata_q <= req_wdata_i;
      end
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_rdata_o    = rsp_data_q;
  assign nl_req_valid_o = (state_q == ST_SEND);
  assign nl_req_write_o = pend_write_q;
  assign nl_req_addr_o  = pend_addr_q;
  assign nl_req_wdata_o = pend_wdata_q;
  assign pend_addr      = pend_addr_q;
endmodule

// File: rtl/lease_l1_cache.sv
module lease_l1_cache #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int TW = 16,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          nl_req_valid_o,
  output logic          nl_req_write_o,
  output logic [AW-1:0] nl_req_addr_o,
  output logic [DW-1:0] nl_req_wdata_o,
  input  logic          nl_req_ready_i,
  input  logic          nl_rsp_valid_i,
  input  logic [DW-1:0] nl_rsp_data_i,
  input  logic [TW-1:0] nl_rsp_expiry_i
);
  localparam int NL  = 1 << IW;
  localparam int TGW = AW - IW;

  logic           line_valid;
  logic [TGW-1:0] line_tag;
  logic [DW-1:0]  line_data;
  logic [TW-1:0]  line_exp;
  logic           line_hit;
  logic           acc_load_hit;
  logic           acc_store;
  logic           store_upd;
  logic           fill_take;
  logic [AW-1:0]  pend_addr;

  lease_lines #(.NL(NL), .IW(IW), .TGW(TGW), .DW(DW), .TW(TW)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(req_addr_i[IW-1:0]),
    .rd_valid(line_valid), .rd_tag(line_tag), .rd_data(line_data), .rd_exp(line_exp),
    .fill_we(fill_take), .fill_idx(pend_addr[IW-1:0]), .fill_tag(pend_addr[AW-1:IW]),
    .fill_data(nl_rsp_data_i), .fill_exp(nl_rsp_expiry_i),
    .upd_we(store_upd), .upd_idx(req_addr_i[IW-1:0]), .upd_data(req_wdata_i)
  );

  lease_probe #(.TGW(TGW), .TW(TW)) u_probe (
    .line_valid(line_valid), .line_tag(line_tag), .line_exp(line_exp),
    .req_tag(req_addr_i[AW-1:IW]), .now(now_i), .hit(line_hit)
  );

  lease_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .line_hit(line_hit), .line_data(line_data),
    .nl_req_ready_i(nl_req_ready_i), .nl_rsp_valid_i(nl_rsp_valid_i),
    .nl_rsp_data_i(nl_rsp_data_i),
    .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .nl_req_valid_o(nl_req_valid_o), .nl_req_write_o(nl_req_write_o),
    .nl_req_addr_o(nl_req_addr_o), .nl_req_wdata_o(nl_req_wdata_o),
    .acc_load_hit(acc_load_hit), .acc_store(acc_store), .store_upd(store_upd),
    .fill_take(fill_take), .pend_addr(pend_addr)
  );
endmodule

// File: rtl/lease_l1_checker.sv
module lease_l1_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          nl_req_valid_o,
  input logic          nl_req_ready_i,
  input logic [AW-1:0] nl_req_addr_o,
  input logic          acc_load_hit,
  input logic          acc_store,
  input logic          fill_take
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_req_valid_o && !nl_req_ready_i) |=> (nl_req_valid_o && $stable(nl_req_addr_o)));

  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !nl_req_valid_o);

  assert_rsp_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(acc_load_hit || fill_take));

  assert_hit_stays_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_load_hit |=> (!nl_req_valid_o && rsp_valid_o));

  assert_store_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_store |=> (!rsp_valid_o && nl_req_valid_o));
endmodule

bind lease_l1_cache lease_l1_checker #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .nl_req_valid_o(nl_req_valid_o), .nl_req_ready_i(nl_req_ready_i),
  .nl_req_addr_o(nl_req_addr_o), .acc_load_hit(acc_load_hit),
  .acc_store(acc_store), .fill_take(fill_take)
);

// File: tb/test_lease_l1_cache.sv
`timescale 1ns/1ps
module test_lease_l1_cache;
  localparam int AW = 8, DW = 16, TW = 16, IW = 2, NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] now_i = '0;
  logic          req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          req_ready_o, rsp_valid_o;
  logic [DW-1:0] rsp_rdata_o;
  logic          nl_req_valid_o, nl_req_write_o;
  logic [AW-1:0] nl_req_addr_o;
  logic [DW-1:0] nl_req_wdata_o;
  logic          nl_req_ready_i = 1'b1, nl_rsp_valid_i = 1'b0;
  logic [DW-1:0] nl_rsp_data_i = '0;
  logic [TW-1:0] nl_rsp_expiry_i = '0;

  int checks = 0, errors = 0;

  // bench-side model
  logic [DW-1:0] mem [256];
  logic          m_vld [NL];
  logic [AW-1:0] m_addr [NL];
  logic [DW-1:0] m_data [NL];
  logic [TW-1:0] m_exp [NL];

  always #4 clk = ~clk;

  lease_l1_cache #(.AW(AW), .DW(DW), .TW(TW), .IW(IW)) i_lease_l1_cache (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic alive(logic [TW-1:0] e, logic [TW-1:0] n);
    logic [TW-1:0] d;
    d = e - n;
    return d != 0 && d < (1 << (TW - 1));
  endfunction

  function automatic logic model_hit(logic [AW-1:0] a);
    int l;
    l = a % NL;
    return m_vld[l] && m_addr[l] == a && alive(m_exp[l], now_i);
  endfunction

  task automatic do_load(logic [AW-1:0] a, logic [TW-1:0] lease, string req);
    logic h;
    int l;
    l = a % NL;
    h = model_hit(a);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    if (h) begin
      chk({req, " hit rsp"}, rsp_valid_o, 1);
      chk({req, " hit data"}, rsp_rdata_o, m_data[l]);
      chk({req, " hit no nl req"}, nl_req_valid_o, 0);
    end else begin
      chk({req, " miss rsp low"}, rsp_valid_o, 0);
      chk({req, " R9 ready low"}, req_ready_o, 0);
      chk({req, " R4 nl req"}, {nl_req_valid_o, nl_req_write_o, nl_req_addr_o}, {2'b10, a});
      @(posedge clk);
      @(negedge clk);
      chk({req, " R9 ready low wait"}, req_ready_o, 0);
      nl_rsp_valid_i = 1'b1; nl_rsp_data_i = mem[a]; nl_rsp_expiry_i = lease;
      @(posedge clk);
      @(negedge clk);
      nl_rsp_valid_i = 1'b0;
      chk({req, " R5 fill rsp"}, rsp_valid_o, 1);
      chk({req, " R5 fill data"}, rsp_rdata_o, mem[a]);
      chk({req, " R9 ready back"}, req_ready_o, 1);
      m_vld[l] = 1'b1; m_addr[l] = a; m_data[l] = mem[a]; m_exp[l] = lease;
    end
  endtask

  task automatic do_store(logic [AW-1:0] a, logic [DW-1:0] d, string req);
    int l;
    l = a % NL;
    if (model_hit(a)) m_data[l] = d;   // R7: expiry kept; R8: no allocation on miss
    mem[a] = d;
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk({req, " R6 wt req"}, {nl_req_valid_o, nl_req_write_o, nl_req_addr_o, nl_req_wdata_o},
        {2'b11, a, d});
    chk({req, " R6 no rsp"}, rsp_valid_o, 0);
    chk({req, " R9 ready low"}, req_ready_o, 0);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R6 done"}, {req_ready_o, nl_req_valid_o, rsp_valid_o}, 3'b100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(16'h1000 + i * 7);
    for (int i = 0; i < NL; i++) begin
      m_vld[i] = 1'b0; m_addr[i] = '0; m_data[i] = '0; m_exp[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {req_ready_o, rsp_valid_o, nl_req_valid_o}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {req_ready_o, rsp_valid_o, nl_req_valid_o}, 3'b100);

    // R1: every line empty -> misses
    now_i = 16'd100;
    for (int a = 0; a < NL; a++) do_load(AW'(a), 16'd120, "R1 cold");

    // R2/R3 sweep: lease length vs time step, exact expiry edge
    for (int a = 0; a < 16; a++) begin
      for (int lease = 1; lease <= 3; lease++) begin
        now_i = 16'd200;
        do_load(AW'(a), TW'(200 + lease), "R3 refill");
        for (int t = 0; t <= lease; t++) begin
          now_i = TW'(200 + t);
          do_load(AW'(a), TW'(200 + t + lease), "R2 R3 sweep");
        end
      end
    end

    // R3: wraparound
    now_i = 16'hFFF0;
    do_load(8'h20, 16'h0010, "R3 wrap fill");
    now_i = 16'hFFFF; do_load(8'h20, 16'h0010, "R3 wrap live");
    chk("R3 wrap was hit", m_exp[0], 16'h0010);
    now_i = 16'h000F; do_load(8'h20, 16'h0010, "R3 wrap live late");
    now_i = 16'h0010; do_load(8'h20, 16'h0400, "R3 wrap expire");
    // expiry half range ahead counts as past
    now_i = 16'h0100;
    m_vld[1] = 1'b0;
    do_load(8'h21, 16'h8100, "R3 half range fill");
    do_load(8'h21, 16'h0200, "R3 half range stale");
    do_load(8'h21, 16'h0200, "R3 near lease live");

    // R7: store hit updates word, expiry unchanged
    now_i = 16'h0300;
    do_load(8'h42, 16'h0305, "R7 fill");
    do_store(8'h42, 16'hBEEF, "R7 store hit");
    do_load(8'h42, 16'h0999, "R7 read updated");
    now_i = 16'h0304; do_load(8'h42, 16'h0999, "R7 still live");
    now_i = 16'h0305; do_load(8'h42, 16'h0999, "R7 old expiry kept");

    // R8: store miss does not allocate
    now_i = 16'h0400;
    do_store(8'h57, 16'h5A5A, "R8 store miss");
    do_load(8'h57, 16'h0410, "R8 load after store miss");
    chk("R8 fill returned stored value", m_data[3], 16'h5A5A);

    // R10: stale view hidden until expiry
    now_i = 16'h0500;
    do_load(8'h60, 16'h0508, "R10 fill");
    mem[8'h60] = 16'hC0DE;
    now_i = 16'h0507; do_load(8'h60, 16'h0600, "R10 old copy");
    chk("R10 old value held", m_data[0] != 16'hC0DE, 1);
    now_i = 16'h0508; do_load(8'h60, 16'h0600, "R10 new after expiry");

    // R4: request held while next level stalls
    now_i = 16'h0700;
    nl_req_ready_i = 1'b0;
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = 8'h73;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R4 held", {nl_req_valid_o, nl_req_addr_o, req_ready_o}, {1'b1, 8'h73, 1'b0});
      @(negedge clk);
    end
    nl_req_ready_i = 1'b1;
    @(negedge clk);
    chk("R4 released", {nl_req_valid_o, req_ready_o}, 2'b00);
    nl_rsp_valid_i = 1'b1; nl_rsp_data_i = mem[8'h73]; nl_rsp_expiry_i = 16'h0710;
    @(negedge clk);
    nl_rsp_valid_i = 1'b0;
    chk("R5 stalled fill", {rsp_valid_o, rsp_rdata_o}, {1'b1, mem[8'h73]});
    m_vld[3] = 1'b1; m_addr[3] = 8'h73; m_data[3] = mem[8'h73]; m_exp[3] = 16'h0710;
    do_load(8'h73, 16'h0800, "R2 after stalled fill");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule